// File: doc/BRIEF.md
# Uncore Performance Counter Bank

This block counts hardware events for performance monitoring. It holds eight 64-bit counters. Each counter uses an 8-bit code to choose one line out of a 256-wide event pulse vector. Software sets up the counters through a 32-bit register bus, which carries the control, event-select, interrupt-mask, interrupt-status, clear and version registers. A separate 64-bit access path reads and writes the counter values.

The bank also models a power-saving clock gate. Counter state advances only while the global run bit is set. While that bit is clear, the counters hold their values, and any software write to a counter is lost. When a counter wraps from all ones to zero, it sets a sticky status bit. The interrupt output is high while any status bit is set whose mask bit is clear.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter reads zero, the control register reads zero, the status register reads zero, the mask register reads 0xFF and `irq` is low.
- R2: Register layout on the 32-bit bus:
  - Control at 0x1C00: bit 26 is the global run bit, bits 7:0 are the per-counter enables, and all other bits read zero.
  - Event select at 0x1D00 and 0x1D04: counter i uses the byte at bits 8*(i%4)+7 : 8*(i%4) of the register at 0x1D00 + 4*(i/4).
  - Mask at 0x0800: bits 7:0.
  - Status at 0x0808: read-only.
  - Clear at 0x080C: write-only, reads zero.
- R3: The register at 0x1CF0 always reads the VERSION parameter (default 0x00000002), and writes to it have no effect.
- R4: A counter adds exactly one at each clock edge where its selected event line is high, provided the global run bit and its own enable bit are both set.
- R5: A counter whose enable bit is clear holds its value while its event pulses.
- R6: While the global run bit is clear, no counter changes on event pulses.
- R7: A 64-bit write at 0x1E00 + 8*n loads counter n while the global run bit is set. If an event counts on the same edge, the write wins.
- R8: A 64-bit counter write issued while the global run bit is clear is lost, and the counter keeps its old value.
- R9: When an increment carries a counter from all ones, the counter becomes zero and its status bit is set.
- R10: `irq` is high exactly when some status bit is set whose mask bit is clear. A set mask bit suppresses that counter's interrupt.
- R11: Writing a word to 0x080C clears each status bit whose corresponding data bit is 1. Zero data bits leave status unchanged. A wrap on the same edge as a clear leaves the bit set.
- R12: On either bus, reads of unmapped or misaligned offsets return zero and writes to them change nothing. This includes 0x1D08 and offsets 0x1E04 and 0x1E40 on the 64-bit path.
- R13: Read data on both paths is registered. It is captured at the edge where the read is presented and then held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 32-bit bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read on the 32-bit bus |
| reg_addr | input | 16 | Byte offset on the 32-bit bus |
| reg_wdata | input | 32 | Write data, 32-bit bus |
| reg_rdata | output | 32 | Registered read data, 32-bit bus |
| cnt_sel | input | 1 | 64-bit counter path access strobe |
| cnt_wr | input | 1 | 1 = write, 0 = read on the counter path |
| cnt_addr | input | 16 | Byte offset on the counter path |
| cnt_wdata | input | 64 | Counter write data |
| cnt_rdata | output | 64 | Registered counter read data |
| ev_pulse | input | 256 | Event pulse lines, one per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
Each result has a known due time after its stimulus:
- A register or counter write takes effect at the edge where it is presented.
- A read returns its data after that same edge, so the bench samples on the following falling edge.
- An event pulse held high through one edge shows in the counter after that edge.
- A wrap sets the status bit at the same edge, and `irq` follows it combinationally.

All stimulus is driven on falling edges. Each read task samples on the falling edge right after the capturing edge, so every comparison sees the cycle that the requirement names.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 16;
  localparam int GLB_BIT = 26;

  localparam logic [ADDR_W-1:0] OFS_MASK  = 16'h0800;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0808;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 16'h080C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 16'h1C00;
  localparam logic [ADDR_W-1:0] OFS_VER   = 16'h1CF0;
  localparam logic [ADDR_W-1:0] OFS_EVSEL = 16'h1D00;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 16'h1E00;
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int EV_W = 8,
  parameter logic [31:0] VERSION = 32'h0000_0002
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic [NUM_CNT-1:0]      status,
  output logic [31:0]             rdata,
  output logic                    glb_en,
  output logic [NUM_CNT-1:0]      run_en,
  output logic [NUM_CNT*EV_W-1:0] evsel,
  output logic [NUM_CNT-1:0]      mask,
  output logic [NUM_CNT-1:0]      clr_vec
);
  localparam int NUM_SELREG = (NUM_CNT * EV_W + 31) / 32;
  localparam int SI_W = (NUM_SELREG > 1) ? $clog2(NUM_SELREG) : 1;
  localparam logic [ADDR_W-1:0] SEL_SPAN = ADDR_W'(4 * NUM_SELREG);

  logic [NUM_SELREG*32-1:0] sel_q;
  logic                     glb_q;
  logic [NUM_CNT-1:0]       en_q;
  logic [NUM_CNT-1:0]       mask_q;
  logic [31:0]              rdata_q;

  // decode
  logic              wr_go, rd_go;
  logic              hit_ctrl, hit_mask, hit_stat, hit_clr, hit_ver, hit_sel;
  logic [ADDR_W-1:0] sel_off;
  logic [SI_W-1:0]   sel_idx;

  assign wr_go    = sel && wr;
  assign rd_go    = sel && !wr;
  assign hit_ctrl = (addr == OFS_CTRL);
  assign hit_mask = (addr == OFS_MASK);
  assign hit_stat = (addr == OFS_STAT);
  assign hit_clr  = (addr == OFS_CLR);
  assign hit_ver  = (addr == OFS_VER);
  assign sel_off  = addr - OFS_EVSEL;
  assign hit_sel  = (addr >= OFS_EVSEL) && (sel_off < SEL_SPAN) && (addr[1:0] == 2'b00);
  assign sel_idx  = SI_W'(sel_off >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      glb_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
    end else if (wr_go) begin
      if (hit_ctrl) begin
        glb_q <= wdata[GLB_BIT];
        en_q  <= wdata[NUM_CNT-1:0];
      end
      if (hit_mask) mask_q <= wdata[NUM_CNT-1:0];
      for (int k = 0; k < NUM_SELREG; k++) begin
        if (hit_sel && (sel_idx == SI_W'(k))) sel_q[k*32 +: 32] <= wdata;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[GLB_BIT]       = glb_q;
      rd_mux[NUM_CNT-1:0]   = en_q;
    end
    if (hit_mask) rd_mux[NUM_CNT-1:0] = mask_q;
    if (hit_stat) rd_mux[NUM_CNT-1:0] = status;
    if (hit_ver)  rd_mux = VERSION;
    if (hit_sel)  rd_mux = sel_q[sel_idx*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign glb_en  = glb_q;
  assign run_en  = en_q;
  assign evsel   = sel_q[NUM_CNT*EV_W-1:0];
  assign mask    = mask_q;
  assign clr_vec = (wr_go && hit_clr) ? wdata[NUM_CNT-1:0] : '0;
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 64,
  parameter int EV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_en,
  input  logic               run_en,
  input  logic [EV_W-1:0]    ev_code,
  input  logic [2**EV_W-1:0] events,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count,
  output logic               inc,
  output logic               wrap
);
  // returns {carry, sum} of val plus one
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] val);
    return {1'b0, val} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;

  assign nxt  = bump(cnt_q);
  assign inc  = gate_en && run_en && events[ev_code];
  assign wrap = inc && !wr_en && nxt[CNT_W];

  // gate_en models the counter clock: nothing changes while it is low
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (gate_en) begin
      if (wr_en)      cnt_q <= wr_data;
      else if (inc)   cnt_q <= nxt[CNT_W-1:0];
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] set_vec,
  input  logic [NUM_CNT-1:0] clr_vec,
  input  logic [NUM_CNT-1:0] mask,
  output logic [NUM_CNT-1:0] status,
  output logic               irq
);
  // a new wrap outranks a clear on the same edge
  function automatic logic [NUM_CNT-1:0] next_status(
    input logic [NUM_CNT-1:0] cur,
    input logic [NUM_CNT-1:0] set,
    input logic [NUM_CNT-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  logic [NUM_CNT-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= next_status(st_q, set_vec, clr_vec);
  end

  assign status = st_q;
  assign irq    = |(st_q & ~mask);
endmodule

// File: rtl/pmc_wide.sv
module pmc_wide
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CNT*CNT_W-1:0] counts,
  output logic [CNT_W-1:0]         rdata,
  output logic [NUM_CNT-1:0]       wr_vec
);
  localparam int CI_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [CI_W-1:0]   idx;
  logic [CNT_W-1:0]  rdata_q;

  assign off = addr - OFS_CNT;
  assign hit = (addr >= OFS_CNT) && (off < CNT_SPAN) && (addr[2:0] == 3'b000);
  assign idx = CI_W'(off >> 3);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_wr
    assign wr_vec[i] = sel && wr && hit && (idx == CI_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rdata_q <= '0;
    else if (sel && !wr)   rdata_q <= hit ? counts[idx*CNT_W +: CNT_W] : '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W = 64,
  parameter int EV_W = 8,
  parameter logic [31:0] VERSION = 32'h0000_0002,
  localparam int NUM_EV = 2 ** EV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cnt_sel,
  input  logic              cnt_wr,
  input  logic [ADDR_W-1:0] cnt_addr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  input  logic [NUM_EV-1:0] ev_pulse,
  output logic              irq
);
  // named internal events, also observed by the checker
  logic                     glb_en;
  logic [NUM_CNT-1:0]       run_en;
  logic [NUM_CNT*EV_W-1:0]  evsel;
  logic [NUM_CNT-1:0]       mask;
  logic [NUM_CNT-1:0]       clr_vec;
  logic [NUM_CNT-1:0]       status;
  logic [NUM_CNT-1:0]       inc_vec;
  logic [NUM_CNT-1:0]       wrap_vec;
  logic [NUM_CNT-1:0]       cnt_wr_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  pmc_regs #(.NUM_CNT(NUM_CNT), .EV_W(EV_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .rdata(reg_rdata), .glb_en(glb_en),
    .run_en(run_en), .evsel(evsel), .mask(mask), .clr_vec(clr_vec)
  );

  pmc_wide #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .sel(cnt_sel), .wr(cnt_wr), .addr(cnt_addr),
    .counts(cnt_flat), .rdata(cnt_rdata), .wr_vec(cnt_wr_vec)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmc_counter #(.CNT_W(CNT_W), .EV_W(EV_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .gate_en(glb_en), .run_en(run_en[i]),
      .ev_code(evsel[i*EV_W +: EV_W]), .events(ev_pulse),
      .wr_en(cnt_wr_vec[i]), .wr_data(cnt_wdata),
      .count(cnt_flat[i*CNT_W +: CNT_W]), .inc(inc_vec[i]), .wrap(wrap_vec[i])
    );
  end

  pmc_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(wrap_vec), .clr_vec(clr_vec),
    .mask(mask), .status(status), .irq(irq)
  );
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W = 64,
  parameter logic [31:0] VERSION = 32'h0000_0002
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     glb_en,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       status,
  input logic [NUM_CNT-1:0]       mask,
  input logic                     irq,
  input logic [NUM_CNT-1:0]       wrap_vec,
  input logic [NUM_CNT-1:0]       inc_vec,
  input logic [NUM_CNT-1:0]       cnt_wr_vec,
  input logic [NUM_CNT-1:0]       clr_vec,
  input logic                     reg_sel,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_rdata
);
  AST_VERSION_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == OFS_VER) |=> (reg_rdata == VERSION)); // R3

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vec[0] && !cnt_wr_vec[0]) |=>
      (cnt_flat[CNT_W-1:0] == $past(cnt_flat[CNT_W-1:0]) + CNT_W'(1))); // R4

  AST_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> $stable(cnt_flat)); // R6

  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((status & $past(wrap_vec)) == $past(wrap_vec))); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_vec)) & ~status) == '0)); // R11
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cnt_flat(cnt_flat),
  .status(status), .mask(mask), .irq(irq), .wrap_vec(wrap_vec),
  .inc_vec(inc_vec), .cnt_wr_vec(cnt_wr_vec), .clr_vec(clr_vec),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_pmc_bank.sv
`timescale 1ns/1ps
module sim_pmc_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_sel = 1'b0, reg_wr = 1'b0;
  logic [15:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         cnt_sel = 1'b0, cnt_wr = 1'b0;
  logic [15:0]  cnt_addr = '0;
  logic [63:0]  cnt_wdata = '0;
  logic [63:0]  cnt_rdata;
  logic [255:0] ev_pulse = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmc_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_sel(cnt_sel), .cnt_wr(cnt_wr), .cnt_addr(cnt_addr),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .ev_pulse(ev_pulse), .irq(irq)
  );

  // {tag, addr, write data, expected read-back}
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {8'd2,  16'h1C00, 32'hFFFF_FFFF, 32'h0400_00FF},  // R2 control fields
    {8'd2,  16'h1D00, 32'h1234_5678, 32'h1234_5678},  // R2 select reg 0
    {8'd2,  16'h1D04, 32'h9ABC_DEF0, 32'h9ABC_DEF0},  // R2 select reg 1
    {8'd2,  16'h0800, 32'hFFFF_FF0F, 32'h0000_000F},  // R2 mask width
    {8'd3,  16'h1CF0, 32'hFFFF_FFFF, 32'h0000_0002},  // R3 version read-only
    {8'd2,  16'h0808, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 status read-only
    {8'd2,  16'h080C, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 clear reads zero
    {8'd12, 16'h0100, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 unmapped
    {8'd12, 16'h1D08, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 past select regs
    {8'd2,  16'h1C00, 32'h0000_0000, 32'h0000_0000},  // R2 control off
    {8'd2,  16'h0800, 32'h0000_00FF, 32'h0000_00FF}   // R2 mask restore
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cnt_write(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    cnt_sel = 1'b1; cnt_wr = 1'b1; cnt_addr = a; cnt_wdata = d;
    @(negedge clk);
    cnt_sel = 1'b0; cnt_wr = 1'b0;
  endtask

  task automatic cnt_read(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    cnt_sel = 1'b1; cnt_wr = 1'b0; cnt_addr = a;
    @(negedge clk);
    cnt_sel = 1'b0;
    d = cnt_rdata;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ev_pulse = '0;
      ev_pulse[idx] = 1'b1;
    end
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r32;
    logic [63:0] r64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    reg_read(16'h1C00, r32); chk("R1 ctrl", {32'd0, r32}, 64'd0);
    reg_read(16'h0800, r32); chk("R1 mask", {32'd0, r32}, 64'hFF);
    reg_read(16'h0808, r32); chk("R1 status", {32'd0, r32}, 64'd0);
    cnt_read(16'h1E38, r64); chk("R1 counter7", r64, 64'd0);

    // table walk: write then read back
    for (int v = 0; v < NV; v++) begin
      reg_write(VEC[v][79:64], VEC[v][63:32]);
      reg_read(VEC[v][79:64], r32);
      chk($sformatf("R%0d table %0d", VEC[v][87:80], v), {32'd0, r32}, {32'd0, VEC[v][31:0]});
    end

    // R13 read data held after the read
    reg_read(16'h1CF0, r32);
    @(negedge clk); reg_addr = 16'h0800;
    @(negedge clk);
    chk("R13 hold", {32'd0, reg_rdata}, 64'h2);

    // R4 / R5: counter0 code 05, counter1 code 05 (disabled), counter3 code FA
    reg_write(16'h1D00, 32'hFA00_0505);
    reg_write(16'h1C00, 32'h0400_0009);
    pulse(5, 4);
    pulse(8'hFA, 2);
    cnt_read(16'h1E00, r64); chk("R4 counter0", r64, 64'd4);
    cnt_read(16'h1E18, r64); chk("R4 counter3 lane3", r64, 64'd2);
    cnt_read(16'h1E08, r64); chk("R5 counter1 disabled", r64, 64'd0);

    // R6 global off, R8 write lost
    reg_write(16'h1C00, 32'h0000_00FF);
    pulse(5, 3);
    cnt_read(16'h1E00, r64); chk("R6 held", r64, 64'd4);
    cnt_write(16'h1E00, 64'h55);
    cnt_read(16'h1E00, r64); chk("R8 write lost", r64, 64'd4);

    // R7 write with global on
    reg_write(16'h1C00, 32'h0400_0000);
    cnt_write(16'h1E00, 64'h1234_5678_9ABC_DEF0);
    cnt_read(16'h1E00, r64); chk("R7 write taken", r64, 64'h1234_5678_9ABC_DEF0);

    // R9 wrap on counter2, code 07 at lane 2
    reg_write(16'h1D00, 32'hFA07_0505);
    cnt_write(16'h1E10, 64'hFFFF_FFFF_FFFF_FFFE);
    reg_write(16'h1C00, 32'h0400_0004);
    pulse(7, 1);
    reg_read(16'h0808, r32); chk("R9 no early flag", {32'd0, r32}, 64'd0);
    pulse(7, 1);
    cnt_read(16'h1E10, r64); chk("R9 wrapped", r64, 64'd0);
    reg_read(16'h0808, r32); chk("R9 status bit2", {32'd0, r32}, 64'h4);
    chk("R10 masked", {63'd0, irq}, 64'd0);
    reg_write(16'h0800, 32'h0000_00FB);
    chk("R10 unmasked", {63'd0, irq}, 64'd1);

    // R11 clear
    reg_write(16'h080C, 32'h0000_0003);
    reg_read(16'h0808, r32); chk("R11 zero bits keep", {32'd0, r32}, 64'h4);
    reg_write(16'h080C, 32'h0000_0004);
    reg_read(16'h0808, r32); chk("R11 cleared", {32'd0, r32}, 64'd0);
    chk("R11 irq low", {63'd0, irq}, 64'd0);

    // R12 wide path unmapped / misaligned
    cnt_write(16'h1E04, 64'd0);
    cnt_read(16'h1E00, r64); chk("R12 misaligned write", r64, 64'h1234_5678_9ABC_DEF0);
    cnt_read(16'h1E04, r64); chk("R12 misaligned read", r64, 64'd0);
    cnt_read(16'h1E40, r64); chk("R12 past counters", r64, 64'd0);

    done = 1'b1;
    finish_run();
  end
endmodule